// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block produces one pulse-width modulated waveform from an 8-bit counter. The counter is compared against an active period value and an active duty value. Software writes period and duty through a simple write strobe interface. While the channel runs, those writes land in a buffer and are copied into the active values only at a safe point. Each generated cycle therefore follows either the old settings or the new ones, never a mix of the two.

Counting advances only on a clock-enable strobe that comes from an external prescaler. The enable request is also sampled on that strobe, so the channel starts and stops on a strobe boundary. The first waveform cycle after enabling may be shortened or lengthened.

The polarity input chooses the level at which each cycle starts. The alignment input chooses between a sawtooth count, which is edge-aligned, and a triangle count, which is center-aligned. Writing the counter clears it and forces the buffered settings into effect at once. The counter can be read at any time.

Top module: `pwm_chan`

## Requirements
- R1: With `pol`=1 each cycle starts high and the output goes low once the count reaches the active duty value. With `pol`=0 the levels are swapped. The output is at the starting level exactly while count < duty.
- R2: With `center`=0 and a nonzero period P, the counter steps 0,1,…,P-1 and then returns to 0. The return to 0 ends the period.
- R3: With `center`=1 and a nonzero period P, the counter steps 0,1,…,P,P-1,…,0 and then climbs again. The period ends each time the counter leaves 0 on the way down. The output changes level at the duty crossing in both directions.
- R4: While the channel is enabled, a write to period or duty alters only the buffer. The active value changes at the next period end, at a counter write, or when the channel is disabled.
- R5: A counter write (`wr_cnt`) makes `cnt_rd` read 0 after that clock edge. It restarts the count upward and copies both buffers into the active values.
- R6: While the channel is disabled, a period or duty write updates the active value on the same edge.
- R7: While the channel is disabled, the counter holds its value and `pwm_o` equals the inverse of `pol`.
- R8: `en` is sampled only on edges where `tick`=1. The counter advances only on such edges while the channel is enabled.
- R9: If duty ≥ period, the output stays at the starting level for the whole cycle. If duty = 0 and period > 0, the output stays at the opposite level.
- R10: If the active period is 0 and the channel is enabled, the counter stays at 0 and the output stays at the starting level.
- R11: After reset the channel is disabled, the counter reads 0 and all buffered and active values are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Clock-enable strobe from the prescaler |
| en | input | 1 | Channel enable request |
| pol | input | 1 | Starting level of each cycle (1 = high) |
| center | input | 1 | 0 = edge-aligned sawtooth, 1 = center-aligned triangle |
| wr_per | input | 1 | Write strobe for the period value |
| wr_duty | input | 1 | Write strobe for the duty value |
| wr_cnt | input | 1 | Counter write strobe (clears the counter) |
| wdata | input | 8 | Write data for period or duty |
| cnt_rd | output | 8 | Current counter value |
| pwm_o | output | 1 | Waveform output |

## Verification
A wrong active period shows up on `cnt_rd` within one period. The counter wraps early or late, or a triangle count turns at the wrong height. A buffer that leaks into the active duty too soon flips `pwm_o` within the same cycle as the write, before the period end where the change is allowed. A broken enable synchronizer or gating shows up in two ways: the counter moves on a cycle without `tick`, or the output leaves the inactive level before the first strobe. Either is visible within one or two clocks.

// File: rtl/pwm_pkg.sv
// Shared types for the PWM channel.
// Assumes: included first in compile order.
package pwm_pkg;
    typedef enum logic {
        ALIGN_LEFT   = 1'b0,
        ALIGN_CENTER = 1'b1
    } align_e;
endpackage

// File: rtl/pwm_ensync.sv
// Enable synchronizer: samples the enable request only on a prescaler strobe,
// so the channel starts and stops on a strobe boundary.
// Assumes: tick is a single-cycle strobe in the clk domain.
module pwm_ensync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    output logic en_act
);
    // capture the request on strobe edges only
    always_ff @(posedge clk) begin
        if (!rst_n)    en_act <= 1'b0;
        else if (tick) en_act <= en;
    end

    a_r8_sync_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> en_act == $past(en_act));
endmodule

// File: rtl/pwm_shadow.sv
// One double-buffered setting: a buffer written by software and an active
// latch used by the comparator. Writes pass through while disabled.
// Assumes: load is a single-cycle pulse from the counter.
module pwm_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_act,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    output logic [W-1:0] act_o
);
    logic [W-1:0] buf_q;

    // software-side buffer
    always_ff @(posedge clk) begin
        if (!rst_n)  buf_q <= '0;
        else if (wr) buf_q <= wdata;
    end

    // active latch: follows writes when idle, reloads on safe points when running
    always_ff @(posedge clk) begin
        if (!rst_n)       act_o <= '0;
        else if (!en_act) act_o <= wr ? wdata : buf_q;
        else if (load)    act_o <= buf_q;
    end

    a_r4_held_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (en_act && !load) |=> act_o == $past(act_o));
    a_r6_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_act && wr) |=> act_o == $past(wdata));
endmodule

// File: rtl/pwm_counter.sv
// Up/down counter: sawtooth 0..P-1 or triangle 0..P..0, advanced on strobes
// while enabled. Flags the period end that reloads the shadow latches.
// Assumes: per is the active period; a counter write wins over counting.
module pwm_counter #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           en_act,
    input  pwm_pkg::align_e align,
    input  logic           wr_cnt,
    input  logic [W-1:0]   per,
    output logic [W-1:0]   cnt_o,
    output logic           pend_o
);
    import pwm_pkg::*;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_n;
    logic         down_q, down_n;

    // next-count and period-end decode
    always_comb begin
        cnt_n  = cnt_o;
        down_n = down_q;
        pend_o = 1'b0;
        if (wr_cnt) begin
            cnt_n  = '0;
            down_n = 1'b0;
        end else if (en_act && tick) begin
            if (per == '0) begin
                cnt_n  = '0;
                down_n = 1'b0;
                pend_o = 1'b1;
            end else if (align == ALIGN_LEFT) begin
                down_n = 1'b0;
                if (cnt_o >= per - ONE) begin
                    cnt_n  = '0;
                    pend_o = 1'b1;
                end else begin
                    cnt_n = cnt_o + ONE;
                end
            end else if (!down_q) begin
                if (cnt_o >= per) begin
                    cnt_n  = cnt_o - ONE;
                    down_n = 1'b1;
                end else begin
                    cnt_n = cnt_o + ONE;
                end
            end else if (cnt_o == '0) begin
                cnt_n  = ONE;
                down_n = 1'b0;
                pend_o = 1'b1;
            end else begin
                cnt_n = cnt_o - ONE;
            end
        end
    end

    // count and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o  <= '0;
            down_q <= 1'b0;
        end else begin
            cnt_o  <= cnt_n;
            down_q <= down_n;
        end
    end

    a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt_o == '0);
    a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_act && !wr_cnt) |=> $stable(cnt_o));
    a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt_o));
    a_r10_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
        (en_act && tick && per == '0) |=> cnt_o == '0);
endmodule

// File: rtl/pwm_chan.sv
// Top of one PWM channel: enable synchronizer, two shadowed settings, the
// counter and the output compare. Output is decoded from registered state.
// Assumes: one write strobe at a time; wdata valid with the strobe.
module pwm_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         pol,
    input  logic         center,
    input  logic         wr_per,
    input  logic         wr_duty,
    input  logic         wr_cnt,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_rd,
    output logic         pwm_o
);
    import pwm_pkg::*;

    logic         en_act, pend, load;
    logic [W-1:0] per_act, duty_act;
    logic         start_phase;
    align_e       align;

    assign align = center ? ALIGN_CENTER : ALIGN_LEFT;
    assign load  = pend | wr_cnt;

    pwm_ensync u_sync (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .en_act(en_act)
    );

    pwm_shadow #(.W(W)) u_per (
        .clk(clk), .rst_n(rst_n), .en_act(en_act), .wr(wr_per),
        .wdata(wdata), .load(load), .act_o(per_act)
    );

    pwm_shadow #(.W(W)) u_duty (
        .clk(clk), .rst_n(rst_n), .en_act(en_act), .wr(wr_duty),
        .wdata(wdata), .load(load), .act_o(duty_act)
    );

    pwm_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en_act(en_act), .align(align),
        .wr_cnt(wr_cnt), .per(per_act), .cnt_o(cnt_rd), .pend_o(pend)
    );

    // compare: starting level before the duty match, or for the whole cycle
    always_comb begin
        start_phase = (cnt_rd < duty_act) || (duty_act >= per_act);
        pwm_o       = en_act ? (start_phase ? pol : ~pol) : ~pol;
    end

    a_r9_duty_zero_opposite: assert property (@(posedge clk) disable iff (!rst_n)
        (en_act && duty_act == '0 && per_act != '0) |-> pwm_o == ~pol);
    a_r10_zero_period_level: assert property (@(posedge clk) disable iff (!rst_n)
        (en_act && per_act == '0) |-> pwm_o == pol);
endmodule

// File: tb/sim_pwm_chan.sv
module sim_pwm_chan;
    logic       clk = 1'b0;
    logic       rst_n, tick, en, pol, center, wr_per, wr_duty, wr_cnt;
    logic [7:0] wdata, cnt_rd;
    logic       pwm_o;
    int         nchk = 0, nerr = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    pwm_chan u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .pol(pol),
        .center(center), .wr_per(wr_per), .wr_duty(wr_duty), .wr_cnt(wr_cnt),
        .wdata(wdata), .cnt_rd(cnt_rd), .pwm_o(pwm_o)
    );

    typedef struct packed {
        logic [7:0] per;
        logic [7:0] duty;
        logic       pol;
        logic       ctr;
        logic [7:0] pat;   // bit i = expected pwm_o at sample i after enabling
        logic [7:0] cnt7;  // expected counter at sample 7
    } vec_t;

    localparam vec_t VEC [0:8] = '{
        '{8'd4, 8'd1, 1'b1, 1'b0, 8'h11, 8'd3},
        '{8'd4, 8'd1, 1'b0, 1'b0, 8'hEE, 8'd3},
        '{8'd5, 8'd2, 1'b1, 1'b0, 8'h63, 8'd2},
        '{8'd3, 8'd3, 1'b1, 1'b0, 8'hFF, 8'd1},
        '{8'd3, 8'd0, 1'b1, 1'b0, 8'h00, 8'd1},
        '{8'd0, 8'd2, 1'b0, 1'b0, 8'h00, 8'd0},
        '{8'd3, 8'd1, 1'b1, 1'b1, 8'h41, 8'd1},
        '{8'd4, 8'd2, 1'b0, 1'b1, 8'h7C, 8'd1},
        '{8'd2, 8'd2, 1'b1, 1'b1, 8'hFF, 8'd1}
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // disable, clear counter, load period and duty, then enable on a strobe
    task automatic setup(input logic [7:0] p, input logic [7:0] d,
                         input logic pl, input logic c);
        en = 1'b0; tick = 1'b1; cyc();
        wr_cnt = 1'b1; cyc(); wr_cnt = 1'b0;
        wr_per = 1'b1; wdata = p; cyc(); wr_per = 1'b0;
        wr_duty = 1'b1; wdata = d; cyc(); wr_duty = 1'b0;
        pol = pl; center = c; en = 1'b1; cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; en = 1'b0; pol = 1'b0; center = 1'b0;
        wr_per = 1'b0; wr_duty = 1'b0; wr_cnt = 1'b0; wdata = 8'd0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R11 reset state, R7 inactive level
        chk(cnt_rd, 8'd0, "R11 counter after reset");
        chk({7'd0, pwm_o}, 8'd1, "R11 R7 output idle with pol=0");

        // table walk: R1 R2 R3 R6 R9 R10
        for (int v = 0; v < 9; v++) begin
            setup(VEC[v].per, VEC[v].duty, VEC[v].pol, VEC[v].ctr);
            for (int i = 0; i < 8; i++) begin
                chk({7'd0, pwm_o}, {7'd0, VEC[v].pat[i]},
                    $sformatf("R1 R2 R3 R6 R9 R10 vector %0d sample %0d", v, i));
                if (i == 7)
                    chk(cnt_rd, VEC[v].cnt7,
                        $sformatf("R2 R3 R10 vector %0d count", v));
                cyc();
            end
        end

        // R4: a duty write while running waits for the period end
        setup(8'd4, 8'd1, 1'b1, 1'b0);   // count 0
        cyc();                           // count 1
        wr_duty = 1'b1; wdata = 8'd3;
        cyc();                           // count 2
        wr_duty = 1'b0;
        chk({7'd0, pwm_o}, 8'd0, "R4 old duty kept mid-cycle");
        cyc();                           // count 3
        chk({7'd0, pwm_o}, 8'd0, "R4 old duty at count 3");
        cyc(); cyc(); cyc();             // count 0,1,2 under new duty
        chk({7'd0, pwm_o}, 8'd1, "R4 new duty after period end");
        cyc();                           // count 3
        chk({7'd0, pwm_o}, 8'd0, "R4 new duty match");

        // R5: a counter write clears the count and forces the buffered period
        wr_per = 1'b1; wdata = 8'd8; cyc(); wr_per = 1'b0;
        wr_cnt = 1'b1; cyc(); wr_cnt = 1'b0;
        chk(cnt_rd, 8'd0, "R5 count cleared by write");
        repeat (5) cyc();
        chk(cnt_rd, 8'd5, "R5 new period forced in");

        // R8: no counting without a strobe; R7: hold and idle level once off
        en = 1'b0; tick = 1'b0;
        cyc(); cyc();
        chk(cnt_rd, 8'd5, "R8 no strobe no count");
        tick = 1'b1; cyc();              // last counting edge, now disabled
        chk(cnt_rd, 8'd6, "R8 counts on strobe edge");
        repeat (3) cyc();
        chk(cnt_rd, 8'd6, "R7 counter holds when off");
        chk({7'd0, pwm_o}, 8'd0, "R7 idle level for pol=1");
        pol = 1'b0; cyc();
        chk({7'd0, pwm_o}, 8'd1, "R7 idle level for pol=0");

        // R8: enable waits for a strobe
        wr_cnt = 1'b1; cyc(); wr_cnt = 1'b0;
        pol = 1'b1; en = 1'b1; tick = 1'b0;
        cyc(); cyc();
        chk({7'd0, pwm_o}, 8'd0, "R8 still off before strobe");
        tick = 1'b1; cyc();
        chk({7'd0, pwm_o}, 8'd1, "R8 on after strobe");
        tick = 1'b0; cyc();
        tick = 1'b1; cyc();
        tick = 1'b0; cyc();
        tick = 1'b1; cyc();
        chk(cnt_rd, 8'd2, "R8 counting only on strobes");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule